// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Threshold Requests

This block sits between the register interface of an I2C controller and its serial shift engine. It holds two byte FIFOs of equal depth: a transmit FIFO that software fills and the engine drains, and a receive FIFO that the engine fills and software drains. Each FIFO has its own programmable threshold, so software is interrupted once per burst of bytes rather than once per byte.

A transfer begins when software loads a byte count together with its direction. For a transmit, the block asks for data whenever a full burst of bytes both remains to be written and fits in the FIFO. When the final burst is shorter than the threshold, it raises a separate drain request instead. For a receive, it asks software to read once a full burst has arrived. When the byte count is exhausted and a short remainder is left, it raises a receive drain request, and software reads the remainder's size from the status word. Each FIFO can be flushed through a clear bit in the configuration word. Each direction has a DMA request line that copies its ready and drain requests while that direction's DMA enable is set. The FIFO depth is a parameter and is reported in the status word as an encoded field.

Top module: `i2c_fifo_thresh`

## Requirements
- R1: After reset both FIFO levels are 0, every request, DMA and error output is low, and the configuration word reads 0. The status word reads the depth code in bits 15:14 and zeros elsewhere, so it is 16'h4000 at the default depth of 16.
- R2: Bytes written on the data port leave on the engine transmit side in write order. The byte appears on `eng_tx_data` one cycle after an accepted `eng_tx_pop`, and `eng_tx_empty` is high when the transmit FIFO is empty.
- R3: Bytes pushed by the engine are read back on the data port in push order. The byte appears on `dat_rdata` one cycle after an accepted `dat_rd`.
- R4: The status word holds the transmit level in bits 0 upward, the receive level in bits 8 upward, and the depth code s in bits 15:14, where depth = 8 << s. Levels update on the edge that accepts the push, pop or clear.
- R5: In the configuration word, bits 5:0 hold the transmit threshold minus one, bit 6 clears the transmit FIFO, and bit 7 enables transmit DMA. Bits 13:8 hold the receive threshold minus one, bit 14 clears the receive FIFO, and bit 15 enables receive DMA. A clear empties its FIFO on the writing edge, and the clear bits always read back as 0.
- R6: The transmit ready request is high when the bytes software still owes are at least the threshold and the free space is at least the threshold. A threshold field above the depth acts as the full depth.
- R7: The transmit drain request is high when the bytes still owed are between 1 and the threshold minus one and all of them fit in the free space.
- R8: The receive ready request is high when the receive level is at least the threshold.
- R9: The receive drain request is high when no more bytes are due from the engine and the receive level is between 1 and the threshold minus one.
- R10: A count load with the transmit direction sets the owed count and the pop count to the length and the due count to 0. A load with the receive direction sets the due count to the length and the others to 0. Either load clears both error flags.
- R11: A push into a full receive FIFO sets `rx_overrun` until the next count load. The byte is dropped and the level is unchanged.
- R12: A pop from an empty transmit FIFO while transmit bytes remain to be popped sets `tx_underflow` until the next count load. Such a pop with no bytes remaining has no effect.
- R13: Each DMA request equals that direction's ready-or-drain request while its enable bit is set, and is low otherwise. All requests are registered one cycle after the counters and levels they depend on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word written |
| cfg_rdata | output | 16 | Configuration word read back, clear bits as 0 |
| stat_rdata | output | 16 | Status word: levels and depth code |
| xfer_load | input | 1 | Load the transfer byte count |
| xfer_is_tx | input | 1 | Direction of the loaded transfer, 1 = transmit |
| xfer_len | input | 16 | Transfer byte count |
| dat_wr | input | 1 | Software write of one transmit byte |
| dat_wdata | input | 8 | Transmit byte from software |
| dat_rd | input | 1 | Software read of one receive byte |
| dat_rdata | output | 8 | Receive byte to software |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_data | output | 8 | Transmit byte to the engine |
| eng_tx_empty | output | 1 | Transmit FIFO empty |
| eng_rx_push | input | 1 | Engine delivers one receive byte |
| eng_rx_data | input | 8 | Receive byte from the engine |
| eng_rx_full | output | 1 | Receive FIFO full |
| tx_rdy_req | output | 1 | Transmit burst request |
| tx_drain_req | output | 1 | Transmit final partial burst request |
| rx_rdy_req | output | 1 | Receive burst request |
| rx_drain_req | output | 1 | Receive final partial burst request |
| tx_dma_req | output | 1 | Transmit DMA request level |
| rx_dma_req | output | 1 | Receive DMA request level |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
Levels, the status word, error flags and the popped or read bytes are due on the first rising edge after the strobe. Requests and DMA lines are due on the second edge, because they are registered from those levels and counters. The bench drives every strobe on a falling edge and holds it for one cycle. It reads levels, data and flags on the falling edge that follows. Before checking a request it waits one more falling edge, so each check lands half a cycle after the edge that produces its value.

// File: rtl/i2cfifo_pkg.sv
`timescale 1ns/1ps
package i2cfifo_pkg;
  // field positions of the configuration and status words
  localparam int THR_FW       = 6;
  localparam int TX_THR_LSB   = 0;
  localparam int TX_CLR_BIT   = 6;
  localparam int TX_DMA_BIT   = 7;
  localparam int RX_THR_LSB   = 8;
  localparam int RX_CLR_BIT   = 14;
  localparam int RX_DMA_BIT   = 15;
  localparam int ST_TX_LSB    = 0;
  localparam int ST_RX_LSB    = 8;
  localparam int ST_SEL_LSB   = 14;

  typedef struct packed {
    logic              rx_dma;
    logic [THR_FW-1:0] rx_thr_m1;
    logic              tx_dma;
    logic [THR_FW-1:0] tx_thr_m1;
  } buf_cfg_t;
endpackage

// File: rtl/i2cfifo_store.sv
`timescale 1ns/1ps
module i2cfifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_ok, rd_ok;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign wr_ok = wr && !full && !clr;
  assign rd_ok = rd && !empty && !clr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_ok) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R4
  lvl_max_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  // R5
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0));
  // R11
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && full && !rd && !clr) |=> (level == $past(level)));
endmodule

// File: rtl/i2cfifo_req.sv
`timescale 1ns/1ps
module i2cfifo_req
  import i2cfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter bit IS_TX = 1'b1,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [THR_FW-1:0] thr_m1,
  input  logic              dma_en,
  input  logic [LW-1:0]     level,
  input  logic [CW-1:0]     left,
  output logic              rdy,
  output logic              drn,
  output logic              dma
);
  logic [THR_FW:0] raw;
  logic [LW-1:0]   thr;
  logic            rdy_n, drn_n;

  assign raw = {1'b0, thr_m1} + 1'b1;
  assign thr = (raw > (THR_FW+1)'(DEPTH)) ? LW'(DEPTH) : LW'(raw);

  generate
    if (IS_TX) begin : g_tx
      logic [LW-1:0] space;
      assign space = LW'(DEPTH) - level;
      assign rdy_n = (left >= CW'(thr)) && (space >= thr);
      assign drn_n = (left != '0) && (left < CW'(thr)) && (CW'(space) >= left);
    end else begin : g_rx
      assign rdy_n = (level >= thr);
      assign drn_n = (left == '0) && (level != '0) && (level < thr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy <= 1'b0;
      drn <= 1'b0;
      dma <= 1'b0;
    end else begin
      rdy <= rdy_n;
      drn <= drn_n;
      dma <= (rdy_n || drn_n) && dma_en;
    end
  end

  // R7
  rdy_drn_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rdy && drn));
  // R13
  dma_gate_chk: assert property (@(posedge clk) disable iff (rst)
    dma |-> $past(dma_en));
endmodule

// File: rtl/i2c_fifo_thresh.sv
`timescale 1ns/1ps
module i2c_fifo_thresh
  import i2cfifo_pkg::*;
#(
  parameter int DEPTH_SEL = 1,
  parameter int CNT_W     = 16,
  localparam int DEPTH    = 8 << DEPTH_SEL,
  localparam int LW       = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  output logic [15:0]      stat_rdata,
  input  logic             xfer_load,
  input  logic             xfer_is_tx,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic             dat_wr,
  input  logic [7:0]       dat_wdata,
  input  logic             dat_rd,
  output logic [7:0]       dat_rdata,
  input  logic             eng_tx_pop,
  output logic [7:0]       eng_tx_data,
  output logic             eng_tx_empty,
  input  logic             eng_rx_push,
  input  logic [7:0]       eng_rx_data,
  output logic             eng_rx_full,
  output logic             tx_rdy_req,
  output logic             tx_drain_req,
  output logic             rx_rdy_req,
  output logic             rx_drain_req,
  output logic             tx_dma_req,
  output logic             rx_dma_req,
  output logic             tx_underflow,
  output logic             rx_overrun
);
  buf_cfg_t         cfg_q;
  logic             tx_clr, rx_clr;
  logic [LW-1:0]    tx_lvl, rx_lvl;
  logic             tx_full, rx_empty;
  logic [CNT_W-1:0] tx_owed, tx_pop_left, rx_due;

  assign tx_clr = cfg_wr && cfg_wdata[TX_CLR_BIT];
  assign rx_clr = cfg_wr && cfg_wdata[RX_CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (cfg_wr) begin
      cfg_q.tx_thr_m1 <= cfg_wdata[TX_THR_LSB +: THR_FW];
      cfg_q.tx_dma    <= cfg_wdata[TX_DMA_BIT];
      cfg_q.rx_thr_m1 <= cfg_wdata[RX_THR_LSB +: THR_FW];
      cfg_q.rx_dma    <= cfg_wdata[RX_DMA_BIT];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[TX_THR_LSB +: THR_FW] = cfg_q.tx_thr_m1;
    cfg_rdata[TX_DMA_BIT]           = cfg_q.tx_dma;
    cfg_rdata[RX_THR_LSB +: THR_FW] = cfg_q.rx_thr_m1;
    cfg_rdata[RX_DMA_BIT]           = cfg_q.rx_dma;
    stat_rdata = '0;
    stat_rdata[ST_TX_LSB +: LW]   = tx_lvl;
    stat_rdata[ST_RX_LSB +: LW]   = rx_lvl;
    stat_rdata[ST_SEL_LSB +: 2]   = 2'(DEPTH_SEL);
  end

  i2cfifo_store #(.DEPTH(DEPTH), .DW(8)) u_txf (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .wr(dat_wr), .wdata(dat_wdata),
    .rd(eng_tx_pop), .rdata(eng_tx_data),
    .level(tx_lvl), .full(tx_full), .empty(eng_tx_empty)
  );

  i2cfifo_store #(.DEPTH(DEPTH), .DW(8)) u_rxf (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .wr(eng_rx_push), .wdata(eng_rx_data),
    .rd(dat_rd), .rdata(dat_rdata),
    .level(rx_lvl), .full(eng_rx_full), .empty(rx_empty)
  );

  // transfer counters and sticky errors
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_owed      <= '0;
      tx_pop_left  <= '0;
      rx_due       <= '0;
      tx_underflow <= 1'b0;
      rx_overrun   <= 1'b0;
    end else if (xfer_load) begin
      tx_owed      <= xfer_is_tx ? xfer_len : '0;
      tx_pop_left  <= xfer_is_tx ? xfer_len : '0;
      rx_due       <= xfer_is_tx ? '0 : xfer_len;
      tx_underflow <= 1'b0;
      rx_overrun   <= 1'b0;
    end else begin
      if (dat_wr && !tx_full && !tx_clr && tx_owed != '0)
        tx_owed <= tx_owed - 1'b1;
      if (eng_tx_pop && !eng_tx_empty && !tx_clr && tx_pop_left != '0)
        tx_pop_left <= tx_pop_left - 1'b1;
      if (eng_rx_push && rx_due != '0)
        rx_due <= rx_due - 1'b1;
      if (eng_tx_pop && eng_tx_empty && tx_pop_left != '0)
        tx_underflow <= 1'b1;
      if (eng_rx_push && eng_rx_full)
        rx_overrun <= 1'b1;
    end
  end

  i2cfifo_req #(.DEPTH(DEPTH), .CW(CNT_W), .IS_TX(1'b1)) u_txreq (
    .clk(clk), .rst(rst), .thr_m1(cfg_q.tx_thr_m1), .dma_en(cfg_q.tx_dma),
    .level(tx_lvl), .left(tx_owed),
    .rdy(tx_rdy_req), .drn(tx_drain_req), .dma(tx_dma_req)
  );

  i2cfifo_req #(.DEPTH(DEPTH), .CW(CNT_W), .IS_TX(1'b0)) u_rxreq (
    .clk(clk), .rst(rst), .thr_m1(cfg_q.rx_thr_m1), .dma_en(cfg_q.rx_dma),
    .level(rx_lvl), .left(rx_due),
    .rdy(rx_rdy_req), .drn(rx_drain_req), .dma(rx_dma_req)
  );

  // R11
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && eng_rx_full && !xfer_load) |=> rx_overrun);
  // R12
  udf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_tx_pop && eng_tx_empty && !xfer_load && tx_pop_left != '0) |=> tx_underflow);
  // R10
  load_clr_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_load |=> (!tx_underflow && !rx_overrun));
endmodule

// File: tb/tb_i2c_fifo_thresh.sv
`timescale 1ns/1ps
module tb_i2c_fifo_thresh;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        cfg_wr = 0, xfer_load = 0, xfer_is_tx = 0;
  logic [15:0] cfg_wdata = 0, xfer_len = 0;
  logic        dat_wr = 0, dat_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [7:0]  dat_wdata = 0, eng_rx_data = 0;
  logic [15:0] cfg_rdata, stat_rdata;
  logic [7:0]  dat_rdata, eng_tx_data;
  logic eng_tx_empty, eng_rx_full, tx_rdy_req, tx_drain_req, rx_rdy_req, rx_drain_req;
  logic tx_dma_req, rx_dma_req, tx_underflow, rx_overrun;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  i2c_fifo_thresh dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .stat_rdata(stat_rdata),
    .xfer_load(xfer_load), .xfer_is_tx(xfer_is_tx), .xfer_len(xfer_len),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_empty(eng_tx_empty),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_full(eng_rx_full),
    .tx_rdy_req(tx_rdy_req), .tx_drain_req(tx_drain_req),
    .rx_rdy_req(rx_rdy_req), .rx_drain_req(rx_drain_req),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .tx_underflow(tx_underflow), .rx_overrun(rx_overrun)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic wr_cfg(input logic [15:0] v);
    cfg_wr = 1; cfg_wdata = v; step(); cfg_wr = 0;
  endtask
  task automatic load(input logic tx, input logic [15:0] n);
    xfer_load = 1; xfer_is_tx = tx; xfer_len = n; step(); xfer_load = 0;
  endtask
  task automatic put_tx(input logic [7:0] b);
    dat_wr = 1; dat_wdata = b; step(); dat_wr = 0;
  endtask
  task automatic pop_tx(); eng_tx_pop = 1; step(); eng_tx_pop = 0; endtask
  task automatic push_rx(input logic [7:0] b);
    eng_rx_push = 1; eng_rx_data = b; step(); eng_rx_push = 0;
  endtask
  task automatic get_rx(); dat_rd = 1; step(); dat_rd = 0; endtask

  task automatic t_reset();
    check("R1 status", stat_rdata, 16'h4000);
    check("R1 cfg", cfg_rdata, 16'h0000);
    check("R1 reqs", {tx_rdy_req, tx_drain_req, rx_rdy_req, rx_drain_req,
                      tx_dma_req, rx_dma_req, tx_underflow, rx_overrun}, 16'h0);
    check("R2 empty", eng_tx_empty, 1'b1);
  endtask

  task automatic t_tx_order();
    wr_cfg(16'h0003); load(1, 4); step();
    check("R6 ready", tx_rdy_req, 1'b1);
    for (int i = 0; i < 4; i++) put_tx(8'hA1 + 8'(i));
    check("R4 tx level", stat_rdata, 16'h4004);
    step();
    check("R6 ready off", {tx_rdy_req, tx_drain_req}, 2'b00);
    for (int i = 0; i < 4; i++) begin
      pop_tx();
      check("R2 order", eng_tx_data, 8'hA1 + 8'(i));
    end
    check("R2 empty after", eng_tx_empty, 1'b1);
  endtask

  task automatic t_tx_drain();
    load(1, 6); step();
    check("R6 ready 6", tx_rdy_req, 1'b1);
    for (int i = 0; i < 4; i++) put_tx(8'(i));
    step();
    check("R7 drain", {tx_rdy_req, tx_drain_req}, 2'b01);
    put_tx(8'h10); put_tx(8'h11); step();
    check("R7 drain off", tx_drain_req, 1'b0);
    wr_cfg(16'h0043);
    check("R5 tx clear", stat_rdata, 16'h4000);
    check("R5 clear reads 0", cfg_rdata, 16'h0003);
    // space-limited
    load(1, 20);
    for (int i = 0; i < 14; i++) put_tx(8'(i));
    step();
    check("R6 no room", {tx_rdy_req, tx_drain_req}, 2'b00);
    pop_tx(); pop_tx(); step();
    check("R6 room back", tx_rdy_req, 1'b1);
    wr_cfg(16'h0043);
    // clipped threshold
    wr_cfg(16'h003F); load(1, 16); step();
    check("R6 clip ready", tx_rdy_req, 1'b1);
    load(1, 15); step();
    check("R7 clip drain", {tx_rdy_req, tx_drain_req}, 2'b01);
    load(1, 0); step();
  endtask

  task automatic t_rx();
    wr_cfg(16'h0200); load(0, 5);
    push_rx(8'h11); push_rx(8'h12); step();
    check("R9 not yet", {rx_rdy_req, rx_drain_req}, 2'b00);
    check("R10 no tx req", tx_rdy_req, 1'b0);
    check("R4 rx level", stat_rdata, 16'h4200);
    push_rx(8'h13); step();
    check("R8 ready", rx_rdy_req, 1'b1);
    for (int i = 0; i < 3; i++) begin
      get_rx();
      check("R3 order", dat_rdata, 8'h11 + 8'(i));
    end
    step();
    check("R8 ready off", rx_rdy_req, 1'b0);
    push_rx(8'h14); push_rx(8'h15); step();
    check("R9 drain", {rx_rdy_req, rx_drain_req}, 2'b01);
    get_rx(); check("R3 tail a", dat_rdata, 8'h14);
    get_rx(); check("R3 tail b", dat_rdata, 8'h15);
    step();
    check("R9 drain off", rx_drain_req, 1'b0);
  endtask

  task automatic t_overrun();
    load(0, 20);
    for (int i = 0; i < 16; i++) push_rx(8'h40 + 8'(i));
    check("R11 full", {eng_rx_full, rx_overrun}, 2'b10);
    push_rx(8'hEE);
    check("R11 overrun", rx_overrun, 1'b1);
    check("R11 level kept", stat_rdata, 16'h5000);
    get_rx(); check("R11 head", dat_rdata, 8'h40);
    wr_cfg(16'h4200);
    check("R5 rx clear", stat_rdata, 16'h4000);
    check("R5 rx clear reads 0", cfg_rdata, 16'h0200);
    load(0, 0);
    check("R10 flag cleared", rx_overrun, 1'b0);
  endtask

  task automatic t_underflow();
    load(1, 2); pop_tx();
    check("R12 underflow", tx_underflow, 1'b1);
    load(1, 0);
    check("R10 udf cleared", tx_underflow, 1'b0);
    pop_tx();
    check("R12 no remaining", tx_underflow, 1'b0);
  endtask

  task automatic t_dma();
    wr_cfg(16'h0083); load(1, 4); step();
    check("R13 tx dma", {tx_rdy_req, tx_dma_req}, 2'b11);
    wr_cfg(16'h0003); step();
    check("R13 tx dma off", {tx_rdy_req, tx_dma_req}, 2'b10);
    load(1, 0);
    wr_cfg(16'h8000); load(0, 1); push_rx(8'h77); step();
    check("R13 rx dma", {rx_rdy_req, rx_dma_req}, 2'b11);
    get_rx(); check("R3 dma byte", dat_rdata, 8'h77);
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_tx_order();
    t_tx_drain();
    t_rx();
    t_overrun();
    t_underflow();
    t_dma();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule